// File: doc/BRIEF.md
# Configurable Transmit Width Serializer

The block turns parallel transmit data from the fabric side into one serial bit stream. It runs from a single clock at the serial bit rate. Two static configuration inputs choose its shape. The first sets the internal word to 8 or 10 bits. The second sets the fabric frame to one or two internal words. In 10-bit mode line coding is bypassed, so the two bits each word carries beyond its byte come from a pair of side-band inputs for that word, a value bit and a mode bit.

The block generates its own strobes. A one-cycle word strobe marks the last bit of every internal word. A one-cycle fabric strobe marks the last bit of every frame. The fabric drives a new frame and holds it steady across the cycle in which the fabric strobe is high. The block captures the frame at the clock edge that ends that cycle and shifts it out over the next frame-length cycles. Changing either configuration input, or leaving reset, restarts the bit sequence at the first bit of the low word. The first frame after such a restart carries zeros.

Top module: `tx_width_ser`

## Requirements
- R1: With wide_i = 0 each internal word is 8 bits long, and with wide_i = 1 it is 10 bits long. word_stb_o pulses once per word length in cycles.
- R2: With two_i = 0 a frame is one word and fab_stb_o pulses with every word_stb_o. With two_i = 1 a frame is two words and fab_stb_o pulses with every second word_stb_o.
- R3: Within a word, data bit 0 of that word's byte (data_i[8w] for word w) is serialized first and the byte's bit 7 is serialized last among its data bits.
- R4: In a two-word frame, word 0 (data_i[7:0] with side-band index 0) is serialized before word 1 (data_i[15:8] with side-band index 1).
- R5: In a 10-bit word, the eight data bits come first, then side_val_i[w], and side_mode_i[w] is the tenth bit, serialized last.
- R6: In 8-bit mode the side-band inputs have no effect on ser_o. In one-word mode data_i[15:8] and side-band index 1 have no effect on ser_o.
- R7: Inputs are captured only at the clock edge that ends a cycle with fab_stb_o high. The captured frame appears on ser_o over the following frame-length cycles, unaffected by any later change of the inputs.
- R8: word_stb_o is high for exactly one cycle: the cycle that carries the last bit of a word. fab_stb_o is high only together with word_stb_o, in the cycle that carries the last bit of a frame.
- R9: While rst_ni is low, ser_o, word_stb_o and fab_stb_o are 0.
- R10: At the first clock edge after reset release, and at the first clock edge after a change of wide_i or two_i, the sequence restarts at bit 0 of word 0. In the next N cycles (N = word length times words per frame) ser_o is 0, and fab_stb_o goes high in the N-th of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial-rate clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wide_i | input | 1 | Word width select: 0 = 8 bits, 1 = 10 bits |
| two_i | input | 1 | Frame select: 0 = one word, 1 = two words |
| data_i | input | 16 | Frame data, byte w belongs to word w |
| side_val_i | input | 2 | Ninth bit of each 10-bit word, index w for word w |
| side_mode_i | input | 2 | Tenth bit of each 10-bit word, index w for word w |
| ser_o | output | 1 | Serial output bit |
| word_stb_o | output | 1 | High in the last bit cycle of each word |
| fab_stb_o | output | 1 | High in the last bit cycle of each frame; inputs are captured at its end |

## Verification
The bench builds the block with its default parameters: an 8-bit byte, two extra bits per wide word and at most two words per frame. With these values all four width and frame combinations are reachable, and so are the 8, 10, 16 and 20-cycle frame lengths, side-band bits that are used and side-band bits that are ignored. Changing the configuration in the middle of a frame and resetting during operation exercise the restart path from a non-zero bit position. Inputs are changed in the middle of each frame, so a capture at any edge other than the fabric strobe edge produces a wrong recovered word.

// File: rtl/tx_ser_pkg.sv
package tx_ser_pkg;
  localparam int BYTE_W_D    = 8;
  localparam int EXT_W_D     = 2;
  localparam int MAX_WORDS_D = 2;

  typedef struct packed {
    logic wide;
    logic two;
  } ser_cfg_t;
endpackage

// File: rtl/tx_ser_cnt.sv
module tx_ser_cnt #(
  parameter int BYTE_W    = 8,
  parameter int WORD_W    = 10,
  parameter int MAX_WORDS = 2,
  parameter int CNT_W     = $clog2(WORD_W),
  parameter int IDX_W     = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             wide_i,
  input  logic             two_i,
  output logic [CNT_W-1:0] bit_idx_o,
  output logic [IDX_W-1:0] word_idx_o,
  output logic             word_last_o,
  output logic             frame_last_o
);
  logic [CNT_W-1:0] bit_q;
  logic [IDX_W-1:0] word_q;
  logic [CNT_W-1:0] bit_end;
  logic [IDX_W-1:0] word_end;

  assign bit_end  = wide_i ? CNT_W'(WORD_W - 1) : CNT_W'(BYTE_W - 1);
  assign word_end = two_i ? IDX_W'(MAX_WORDS - 1) : '0;

  assign word_last_o  = (bit_q == bit_end);
  assign frame_last_o = word_last_o && (word_q == word_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      word_q <= '0;
    end else if (restart_i) begin
      bit_q  <= '0;
      word_q <= '0;
    end else if (word_last_o) begin
      bit_q  <= '0;
      word_q <= frame_last_o ? '0 : word_q + 1'b1;
    end else begin
      bit_q <= bit_q + 1'b1;
    end
  end

  assign bit_idx_o  = bit_q;
  assign word_idx_o = word_q;
endmodule

// File: rtl/tx_ser_pack.sv
module tx_ser_pack #(
  parameter int BYTE_W    = 8,
  parameter int EXT_W     = 2,
  parameter int MAX_WORDS = 2,
  localparam int WORD_W   = BYTE_W + EXT_W
) (
  input  logic                          wide_i,
  input  logic [MAX_WORDS*BYTE_W-1:0]   data_i,
  input  logic [MAX_WORDS-1:0]          side_val_i,
  input  logic [MAX_WORDS-1:0]          side_mode_i,
  output logic [MAX_WORDS*WORD_W-1:0]   frame_o
);
  for (genvar w = 0; w < MAX_WORDS; w++) begin : g_slot
    logic [EXT_W-1:0] ext;
    // value bit precedes mode bit on the line
    assign ext = wide_i ? EXT_W'({side_mode_i[w], side_val_i[w]}) : '0;
    assign frame_o[w*WORD_W +: WORD_W] = {ext, data_i[w*BYTE_W +: BYTE_W]};
  end
endmodule

// File: rtl/tx_ser_mux.sv
module tx_ser_mux #(
  parameter int WORD_W    = 10,
  parameter int MAX_WORDS = 2,
  parameter int CNT_W     = 4,
  parameter int IDX_W     = 1,
  localparam int FRAME_W  = WORD_W * MAX_WORDS,
  localparam int SEL_W    = $clog2(FRAME_W) + 1
) (
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   bit_idx_i,
  input  logic [IDX_W-1:0]   word_idx_i,
  output logic               bit_o
);
  logic [SEL_W-1:0] sel;

  assign sel = SEL_W'(word_idx_i) * SEL_W'(WORD_W) + SEL_W'(bit_idx_i);

  always_comb begin
    bit_o = 1'b0;
    for (int i = 0; i < FRAME_W; i++) begin
      if (sel == SEL_W'(i)) bit_o = frame_i[i];
    end
  end
endmodule

// File: rtl/tx_width_ser.sv
module tx_width_ser
  import tx_ser_pkg::*;
#(
  parameter int BYTE_W    = BYTE_W_D,
  parameter int EXT_W     = EXT_W_D,
  parameter int MAX_WORDS = MAX_WORDS_D,
  localparam int WORD_W   = BYTE_W + EXT_W,
  localparam int FRAME_W  = WORD_W * MAX_WORDS,
  localparam int CNT_W    = $clog2(WORD_W),
  localparam int IDX_W    = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wide_i,
  input  logic                        two_i,
  input  logic [MAX_WORDS*BYTE_W-1:0] data_i,
  input  logic [MAX_WORDS-1:0]        side_val_i,
  input  logic [MAX_WORDS-1:0]        side_mode_i,
  output logic                        ser_o,
  output logic                        word_stb_o,
  output logic                        fab_stb_o
);
  ser_cfg_t         cfg, cfg_q;
  logic             started_q;
  logic             restart;
  logic [CNT_W-1:0] bit_idx;
  logic [IDX_W-1:0] word_idx;
  logic             word_last, frame_last;
  logic [FRAME_W-1:0] packed_frame, frame_q;

  assign cfg     = '{wide: wide_i, two: two_i};
  assign restart = !started_q || (cfg != cfg_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      cfg_q     <= '0;
    end else begin
      started_q <= 1'b1;
      cfg_q     <= cfg;
    end
  end

  tx_ser_cnt #(
    .BYTE_W   (BYTE_W),
    .WORD_W   (WORD_W),
    .MAX_WORDS(MAX_WORDS),
    .CNT_W    (CNT_W),
    .IDX_W    (IDX_W)
  ) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (restart),
    .wide_i      (wide_i),
    .two_i       (two_i),
    .bit_idx_o   (bit_idx),
    .word_idx_o  (word_idx),
    .word_last_o (word_last),
    .frame_last_o(frame_last)
  );

  tx_ser_pack #(
    .BYTE_W   (BYTE_W),
    .EXT_W    (EXT_W),
    .MAX_WORDS(MAX_WORDS)
  ) u_pack (
    .wide_i     (wide_i),
    .data_i     (data_i),
    .side_val_i (side_val_i),
    .side_mode_i(side_mode_i),
    .frame_o    (packed_frame)
  );

  assign word_stb_o = word_last && !restart;
  assign fab_stb_o  = frame_last && !restart;

  // restart wins over a coinciding load: first frame after restart is zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        frame_q <= '0;
    else if (restart)   frame_q <= '0;
    else if (fab_stb_o) frame_q <= packed_frame;
  end

  tx_ser_mux #(
    .WORD_W   (WORD_W),
    .MAX_WORDS(MAX_WORDS),
    .CNT_W    (CNT_W),
    .IDX_W    (IDX_W)
  ) u_mux (
    .frame_i   (frame_q),
    .bit_idx_i (bit_idx),
    .word_idx_i(word_idx),
    .bit_o     (ser_o)
  );
endmodule

// File: rtl/tx_ser_chk.sv
module tx_ser_chk #(
  parameter int BYTE_W    = 8,
  parameter int EXT_W     = 2,
  parameter int MAX_WORDS = 2,
  localparam int WORD_W   = BYTE_W + EXT_W,
  localparam int GAP_W    = $clog2(WORD_W) + 1
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        wide_i,
  input logic                        two_i,
  input logic [MAX_WORDS*BYTE_W-1:0] data_i,
  input logic [MAX_WORDS-1:0]        side_val_i,
  input logic [MAX_WORDS-1:0]        side_mode_i,
  input logic                        ser_o,
  input logic                        word_stb_o,
  input logic                        fab_stb_o
);
  logic             started_q, seen_q, fseen_q, first_q;
  logic [1:0]       cfg_q;
  logic [GAP_W-1:0] gap_q;
  logic [1:0]       wcnt_q;
  logic             chg;
  logic [GAP_W-1:0] gap_exp;

  assign chg     = started_q && ({wide_i, two_i} != cfg_q);
  assign gap_exp = wide_i ? GAP_W'(WORD_W - 1) : GAP_W'(BYTE_W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      cfg_q     <= '0;
      seen_q    <= 1'b0;
      fseen_q   <= 1'b0;
      first_q   <= 1'b1;
      gap_q     <= '0;
      wcnt_q    <= '0;
    end else begin
      started_q <= 1'b1;
      cfg_q     <= {wide_i, two_i};
      if (chg) begin
        seen_q  <= 1'b0;
        fseen_q <= 1'b0;
        first_q <= 1'b1;
        gap_q   <= '0;
        wcnt_q  <= '0;
      end else begin
        gap_q <= word_stb_o ? '0 : gap_q + 1'b1;
        if (word_stb_o) seen_q <= 1'b1;
        if (fab_stb_o) begin
          wcnt_q  <= '0;
          fseen_q <= 1'b1;
          first_q <= 1'b0;
        end else if (word_stb_o) begin
          wcnt_q <= wcnt_q + 1'b1;
        end
      end
    end
  end

  AST_WORD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_stb_o && seen_q && !chg) |-> (gap_q == gap_exp)); // R1

  AST_FAB_PAIRING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fab_stb_o && fseen_q && !chg) |-> (wcnt_q == (two_i ? 2'd1 : 2'd0))); // R2

  AST_FAB_ON_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fab_stb_o |-> word_stb_o); // R8

  AST_STB_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_stb_o |=> !word_stb_o); // R8

  AST_ZERO_AFTER_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_q |-> !ser_o); // R10
endmodule

bind tx_width_ser tx_ser_chk #(
  .BYTE_W   (BYTE_W),
  .EXT_W    (EXT_W),
  .MAX_WORDS(MAX_WORDS)
) u_chk (.*);

// File: tb/tx_width_ser_tb.sv
module tx_width_ser_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wide_i = 1'b0;
  logic        two_i = 1'b0;
  logic [15:0] data_i = '0;
  logic [1:0]  side_val_i = '0;
  logic [1:0]  side_mode_i = '0;
  logic        ser_o, word_stb_o, fab_stb_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  tx_width_ser u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wide_i     (wide_i),
    .two_i      (two_i),
    .data_i     (data_i),
    .side_val_i (side_val_i),
    .side_mode_i(side_mode_i),
    .ser_o      (ser_o),
    .word_stb_o (word_stb_o),
    .fab_stb_o  (fab_stb_o)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_word(input bit wide, input int w,
      input logic [15:0] d, input logic [1:0] m, input logic [1:0] v);
    logic [7:0] b;
    b = (w == 0) ? d[7:0] : d[15:8];
    return wide ? {m[w], v[w], b} : {2'b00, b};
  endfunction

  task automatic rand_in();
    data_i      = 16'($urandom);
    side_val_i  = 2'($urandom);
    side_mode_i = 2'($urandom);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // called right after the input change that causes the restart
  task automatic restart_window(input bit wide, input bit two, input string tag);
    int n = (wide ? 10 : 8) * (two ? 2 : 1);
    int ones = 0;
    int fab_at = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (ser_o) ones++;
      if (fab_stb_o && fab_at < 0) fab_at = i;
    end
    check(ones == 0, tag, "zero frame after restart (R10)", ones, 0);
    check(fab_at == n - 1, tag, "fab strobe position after restart (R10)", fab_at, n - 1);
  endtask

  // entered at a negedge where fab_stb_o is high and inputs hold the next frame
  task automatic run_frames(input bit wide, input bit two, input int nf);
    int len = wide ? 10 : 8;
    int nw  = two ? 2 : 1;
    int n   = len * nw;
    for (int f = 0; f < nf; f++) begin
      logic [15:0] d = data_i;
      logic [1:0]  m = side_mode_i;
      logic [1:0]  v = side_val_i;
      logic [19:0] got = '0;
      int wbad = 0;
      int fbad = 0;
      int frame_ok = 1;
      @(posedge clk_i);
      #1;
      case (f)
        0: begin data_i = 16'hFFFF; side_mode_i = 2'b00; side_val_i = 2'b00; end
        1: begin data_i = 16'h0000; side_mode_i = 2'b11; side_val_i = 2'b11; end
        2: begin data_i = 16'hA55A; side_mode_i = 2'b01; side_val_i = 2'b10; end
        default: rand_in();
      endcase
      for (int i = 0; i < n; i++) begin
        @(negedge clk_i);
        got[i] = ser_o;
        if (word_stb_o != ((i % len) == len - 1)) wbad++;
        if (fab_stb_o != (i == n - 1)) fbad++;
        if (i == 3 && f >= 3) rand_in();  // must not reach the current frame
      end
      check(wbad == 0, "R1", "word strobe pattern (R8)", wbad, 0);
      check(fbad == 0, "R2", "fab strobe pattern (R8)", fbad, 0);
      for (int w = 0; w < nw; w++) begin
        logic [9:0] rec = '0;
        logic [9:0] exp = exp_word(wide, w, d, m, v);
        string tag;
        for (int b = 0; b < len; b++) rec[b] = got[w*len + b];
        if (w == 1)      tag = "R4";
        else if (wide)   tag = "R5";
        else if (two)    tag = "R3";
        else             tag = "R6";
        check(rec == exp, tag, $sformatf("word %0d cfg %0d%0d", w, wide, two), rec, exp);
        if (rec != exp) frame_ok = 0;
      end
      check(frame_ok == 1, "R7", "frame captured at fab strobe edge", frame_ok, 1);
    end
  endtask

  task automatic switch_cfg(input bit wide, input bit two, input int nf);
    wide_i = wide;
    two_i  = two;
    restart_window(wide, two, "R10");
    run_frames(wide, two, nf);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    check(0, "R10", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rand_in();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      check(!ser_o && !word_stb_o && !fab_stb_o, "R9", "idle in reset",
            {ser_o, word_stb_o, fab_stb_o}, 0);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
    restart_window(1'b0, 1'b0, "R10");
    run_frames(1'b0, 1'b0, 20);
    switch_cfg(1'b1, 1'b0, 20);
    switch_cfg(1'b0, 1'b1, 20);
    switch_cfg(1'b1, 1'b1, 20);
    // configuration change in the middle of a frame
    repeat (7) @(negedge clk_i);
    rand_in();
    switch_cfg(1'b0, 1'b1, 10);
    repeat (5) @(negedge clk_i);
    rand_in();
    switch_cfg(1'b1, 1'b0, 10);
    // reset during operation
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk_i);
      check(!ser_o && !word_stb_o && !fab_stb_o, "R9", "idle in mid-run reset",
            {ser_o, word_stb_o, fab_stb_o}, 0);
    end
    wide_i = 1'b1;
    two_i  = 1'b1;
    @(negedge clk_i);
    rst_ni = 1'b1;
    restart_window(1'b1, 1'b1, "R10");
    run_frames(1'b1, 1'b1, 10);
    finish_run();
  end
endmodule